// File: doc/BRIEF.md
# Stereo Polyphase FIR Convolution Sequencer

This block runs one FIR convolution for each output sample of a stereo sample rate converter. When an output period begins, a start pulse loads a starting sample-buffer address and a starting coefficient address, both produced by an external rate-tracking loop. The block then walks the taps. The sample address counts down by one on every tap. The coefficient address climbs by a step derived from the output-to-input rate ratio, and that step shrinks when the input runs faster than the output. The convolution ends on the tap where the coefficient address would wrap past the top of the coefficient space. As a result, the filter has 2^TAP_W taps at unity ratio and proportionally more taps when the filter decimates.

A single multiply-accumulate unit is shared in time between the two channels. The left channel is convolved first and the right channel follows immediately, starting again from the same loaded addresses. Sample and coefficient memories are external and have one cycle of read latency. Each channel's result is saturated to the sample width, registered, and announced with a one-cycle valid pulse.

Top module: `fir_conv_seq`

## Requirements
- R1: After reset, rd_o, left_vld_o and right_vld_o are low, and left_o and right_o are zero.
- R2: On the first clock with start_i high while idle, the block latches smp_base_i, coef_base_i and the step derived from ratio_i. The first left tap (rd_o high, smp_ch_o=0) presents exactly those two addresses.
- R3: On each further tap within a channel, smp_addr_o is one less than on the previous tap, wrapping modulo 2^RAM_AW.
- R4: ratio_i is fixed point with RATIO_W fraction bits. Let UNIT = 2^(ROM_AW-TAP_W). When ratio_i >= 2^RATIO_W, the coefficient step is UNIT. Otherwise it is floor(UNIT*ratio_i/2^RATIO_W), with a minimum of 1. On every tap after the first in a channel, coef_addr_o grows by this step.
- R5: A channel ends with the tap whose coef_addr_o + step reaches 2^ROM_AW or more, so it has ceil((2^ROM_AW - coef_base)/step) taps. For coefficient base 0 at unity ratio, that is 2^TAP_W taps.
- R6: The left channel (smp_ch_o=0) runs first. The right channel (smp_ch_o=1) follows on the very next cycle, starting again from the latched bases. rd_o drops after the last right tap.
- R7: smp_i and coef_i are signed and belong to the addresses of the previous cycle. The accumulator is cleared at the first tap of each channel. The result is the tap sum shifted right arithmetically by COEF_W-1 and saturated to the signed DATA_W range.
- R8: left_vld_o and right_vld_o are single-cycle pulses that never occur together. Each appears two cycles after that channel's last tap, and left_o and right_o hold their values until the next result for their channel.
- R9: start_i, ratio_i and the base inputs are ignored while a convolution is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Output period start pulse |
| ratio_i | input | RATIO_W+1 | Output/input rate ratio, RATIO_W fraction bits |
| smp_base_i | input | RAM_AW | Starting sample-buffer address |
| coef_base_i | input | ROM_AW | Starting coefficient address |
| smp_addr_o | output | RAM_AW | Sample-buffer read address |
| smp_ch_o | output | 1 | Channel select for the sample read, 0 left, 1 right |
| coef_addr_o | output | ROM_AW | Coefficient read address |
| rd_o | output | 1 | Tap strobe: both addresses valid this cycle |
| smp_i | input | DATA_W | Sample read data, one cycle after its address |
| coef_i | input | COEF_W | Coefficient read data, one cycle after its address |
| left_o | output | DATA_W | Left channel result |
| left_vld_o | output | 1 | Left result valid pulse |
| right_o | output | DATA_W | Right channel result |
| right_vld_o | output | 1 | Right result valid pulse |

## Verification
The bench builds the block with TAP_W=3, ROM_AW=6, RATIO_W=4, RAM_AW=5 and 8-bit data and coefficients. This gives a coefficient space of 64 entries and a unity step of 8. Every tap count from a single tap up to the 64-tap minimum-step case can be reached in a few hundred cycles. The 32-word buffer per channel lets the sample address wrap below zero inside one convolution. The 8-bit widths make both saturation limits reachable with full-scale memory fills.

// File: rtl/fir_conv_pkg.sv
package fir_conv_pkg;
  typedef enum logic {S_IDLE, S_RUN} seq_state_e;

  typedef struct packed {
    logic vld;
    logic first;
    logic last;
    logic ch;
  } tap_ctl_t;
endpackage

// File: rtl/fir_step_calc.sv
module fir_step_calc #(
  parameter int ROM_AW  = 10,
  parameter int TAP_W   = 6,
  parameter int RATIO_W = 8
) (
  input  logic [RATIO_W:0]  ratio_i,
  output logic [ROM_AW-1:0] step_o
);
  localparam int PROD_W = RATIO_W + ROM_AW;
  localparam logic [ROM_AW-1:0] UNIT = ROM_AW'(1) << (ROM_AW - TAP_W);

  logic [PROD_W-1:0] prod;
  logic [ROM_AW-1:0] scaled;

  assign prod   = PROD_W'(ratio_i[RATIO_W-1:0]) * PROD_W'(UNIT);
  assign scaled = ROM_AW'(prod >> RATIO_W);

  always_comb begin
    if (ratio_i[RATIO_W])        step_o = UNIT;   // ratio >= 1: output not slower
    else if (scaled == '0)       step_o = ROM_AW'(1);
    else                         step_o = scaled;
  end
endmodule

// File: rtl/fir_addr_seq.sv
module fir_addr_seq
  import fir_conv_pkg::*;
#(
  parameter int RAM_AW = 6,
  parameter int ROM_AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ROM_AW-1:0] step_i,
  input  logic [RAM_AW-1:0] smp_base_i,
  input  logic [ROM_AW-1:0] coef_base_i,
  output tap_ctl_t          ctl_o,
  output logic [RAM_AW-1:0] smp_addr_o,
  output logic [ROM_AW-1:0] coef_addr_o,
  output logic [ROM_AW-1:0] step_o
);
  seq_state_e        state_q;
  logic [RAM_AW-1:0] smp_ptr_q, smp_base_q;
  logic [ROM_AW-1:0] coef_ptr_q, coef_base_q, step_q;
  logic              ch_q, first_q;
  logic [ROM_AW:0]   coef_sum;
  logic              last;

  assign coef_sum = {1'b0, coef_ptr_q} + {1'b0, step_q};
  assign last     = coef_sum[ROM_AW];  // coefficient pointer rolls over

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      smp_ptr_q   <= '0;
      smp_base_q  <= '0;
      coef_ptr_q  <= '0;
      coef_base_q <= '0;
      step_q      <= '0;
      ch_q        <= 1'b0;
      first_q     <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q     <= S_RUN;
          smp_ptr_q   <= smp_base_i;
          smp_base_q  <= smp_base_i;
          coef_ptr_q  <= coef_base_i;
          coef_base_q <= coef_base_i;
          step_q      <= step_i;
          ch_q        <= 1'b0;
          first_q     <= 1'b1;
        end
        S_RUN: begin
          if (last) begin
            if (ch_q) begin
              state_q <= S_IDLE;
              first_q <= 1'b0;
            end else begin
              ch_q       <= 1'b1;
              first_q    <= 1'b1;
              smp_ptr_q  <= smp_base_q;
              coef_ptr_q <= coef_base_q;
            end
          end else begin
            smp_ptr_q  <= smp_ptr_q - 1'b1;
            coef_ptr_q <= coef_sum[ROM_AW-1:0];
            first_q    <= 1'b0;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ctl_o.vld   = (state_q == S_RUN);
  assign ctl_o.first = first_q;
  assign ctl_o.last  = last;
  assign ctl_o.ch    = ch_q;
  assign smp_addr_o  = smp_ptr_q;
  assign coef_addr_o = coef_ptr_q;
  assign step_o      = step_q;
endmodule

// File: rtl/fir_mac_sat.sv
module fir_mac_sat
  import fir_conv_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int ROM_AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tap_ctl_t          ctl_i,
  input  logic [DATA_W-1:0] smp_i,
  input  logic [COEF_W-1:0] coef_i,
  output logic [DATA_W-1:0] left_o,
  output logic              left_vld_o,
  output logic [DATA_W-1:0] right_o,
  output logic              right_vld_o
);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int ACC_W  = PROD_W + ROM_AW;
  localparam int FRAC   = COEF_W - 1;
  localparam logic signed [ACC_W-1:0] SAT_MAX = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] SAT_MIN = -SAT_MAX - ACC_W'(1);

  tap_ctl_t                 st_q;   // control aligned with returning read data
  logic signed [ACC_W-1:0]  acc_q, acc_d, shr;
  logic signed [PROD_W-1:0] prod;
  logic [DATA_W-1:0]        sat;

  assign prod  = $signed(smp_i) * $signed(coef_i);
  assign acc_d = st_q.first ? ACC_W'(prod) : acc_q + ACC_W'(prod);
  assign shr   = acc_d >>> FRAC;

  always_comb begin
    if (shr > SAT_MAX)      sat = SAT_MAX[DATA_W-1:0];
    else if (shr < SAT_MIN) sat = SAT_MIN[DATA_W-1:0];
    else                    sat = shr[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= '0;
      acc_q       <= '0;
      left_o      <= '0;
      right_o     <= '0;
      left_vld_o  <= 1'b0;
      right_vld_o <= 1'b0;
    end else begin
      st_q        <= ctl_i;
      left_vld_o  <= 1'b0;
      right_vld_o <= 1'b0;
      if (st_q.vld) begin
        acc_q <= acc_d;
        if (st_q.last) begin
          if (st_q.ch) begin
            right_o     <= sat;
            right_vld_o <= 1'b1;
          end else begin
            left_o      <= sat;
            left_vld_o  <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/fir_conv_seq.sv
module fir_conv_seq
  import fir_conv_pkg::*;
#(
  parameter int RAM_AW  = 6,
  parameter int ROM_AW  = 10,
  parameter int TAP_W   = 6,
  parameter int RATIO_W = 8,
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [RATIO_W:0]   ratio_i,
  input  logic [RAM_AW-1:0]  smp_base_i,
  input  logic [ROM_AW-1:0]  coef_base_i,
  output logic [RAM_AW-1:0]  smp_addr_o,
  output logic               smp_ch_o,
  output logic [ROM_AW-1:0]  coef_addr_o,
  output logic               rd_o,
  input  logic [DATA_W-1:0]  smp_i,
  input  logic [COEF_W-1:0]  coef_i,
  output logic [DATA_W-1:0]  left_o,
  output logic               left_vld_o,
  output logic [DATA_W-1:0]  right_o,
  output logic               right_vld_o
);
  logic [ROM_AW-1:0] step_new, step_q;
  tap_ctl_t          tap_ctl;

  fir_step_calc #(.ROM_AW(ROM_AW), .TAP_W(TAP_W), .RATIO_W(RATIO_W)) u_step (
    .ratio_i (ratio_i),
    .step_o  (step_new)
  );

  fir_addr_seq #(.RAM_AW(RAM_AW), .ROM_AW(ROM_AW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .step_i      (step_new),
    .smp_base_i  (smp_base_i),
    .coef_base_i (coef_base_i),
    .ctl_o       (tap_ctl),
    .smp_addr_o  (smp_addr_o),
    .coef_addr_o (coef_addr_o),
    .step_o      (step_q)
  );

  fir_mac_sat #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ROM_AW(ROM_AW)) u_mac (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_i       (tap_ctl),
    .smp_i       (smp_i),
    .coef_i      (coef_i),
    .left_o      (left_o),
    .left_vld_o  (left_vld_o),
    .right_o     (right_o),
    .right_vld_o (right_vld_o)
  );

  assign rd_o     = tap_ctl.vld;
  assign smp_ch_o = tap_ctl.ch;
endmodule

// File: rtl/fir_conv_seq_chk.sv
module fir_conv_seq_chk #(
  parameter int RAM_AW = 6,
  parameter int ROM_AW = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              rd_o,
  input logic              last_i,
  input logic              smp_ch_o,
  input logic [RAM_AW-1:0] smp_addr_o,
  input logic [ROM_AW-1:0] coef_addr_o,
  input logic [ROM_AW-1:0] step_i,
  input logic              left_vld_o,
  input logic              right_vld_o
);
  a_r3_smp_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o && !last_i |=> rd_o && smp_addr_o == RAM_AW'($past(smp_addr_o) - 1'b1));

  a_r4_coef_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o && !last_i |=> coef_addr_o == ROM_AW'($past(coef_addr_o) + $past(step_i)));

  a_r4_step_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> step_i != '0);

  a_r6_left_to_right: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o && last_i && !smp_ch_o |=> rd_o && smp_ch_o);

  a_r6_right_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o && last_i && smp_ch_o |=> !rd_o);

  a_r6_channel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o && !last_i |=> $stable(smp_ch_o));

  a_r8_vld_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({left_vld_o, right_vld_o}));

  a_r8_left_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_vld_o |=> !left_vld_o);

  a_r9_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o && start_i && !last_i |=> rd_o && $stable(smp_ch_o));
endmodule

bind fir_conv_seq fir_conv_seq_chk #(.RAM_AW(RAM_AW), .ROM_AW(ROM_AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .rd_o        (rd_o),
  .last_i      (tap_ctl.last),
  .smp_ch_o    (smp_ch_o),
  .smp_addr_o  (smp_addr_o),
  .coef_addr_o (coef_addr_o),
  .step_i      (step_q),
  .left_vld_o  (left_vld_o),
  .right_vld_o (right_vld_o)
);

// File: tb/fir_conv_seq_tb.sv
`timescale 1ns/1ps
module fir_conv_seq_tb;
  localparam int RAM_AW = 5, ROM_AW = 6, TAP_W = 3, RATIO_W = 4, DATA_W = 8, COEF_W = 8;
  localparam int UNIT = 2 ** (ROM_AW - TAP_W);
  localparam int ONE  = 2 ** RATIO_W;
  localparam int CSPAN = 2 ** ROM_AW;
  localparam int SSPAN = 2 ** RAM_AW;
  localparam int NV = 11;
  // ratio, sample base, coefficient base, expected taps per channel
  localparam int VR[NV] = '{16, 20,  8, 8,  5,  1, 12, 12, 31, 15,  0};
  localparam int VS[NV] = '{10,  2, 31, 5,  0, 17,  9, 20, 11,  4,  3};
  localparam int VC[NV] = '{ 0,  3,  0, 2,  0,  0,  0,  5, 63,  0,  0};
  localparam int VT[NV] = '{ 8,  8, 16,16, 32, 64, 11, 10,  1, 10, 64};

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [RATIO_W:0]  ratio_i = '0;
  logic [RAM_AW-1:0] smp_base_i = '0;
  logic [ROM_AW-1:0] coef_base_i = '0;
  logic [RAM_AW-1:0] smp_addr_o;
  logic              smp_ch_o, rd_o, left_vld_o, right_vld_o;
  logic [ROM_AW-1:0] coef_addr_o;
  logic [DATA_W-1:0] smp_i = '0, left_o, right_o;
  logic [COEF_W-1:0] coef_i = '0;

  logic signed [DATA_W-1:0] smem [2*SSPAN];
  logic signed [COEF_W-1:0] cmem [CSPAN];

  int nchk = 0, nerr = 0, cyc = 0;
  int m_s, m_c, m_ch, m_step, m_sb, m_cb, addr_err;
  int tcnt [2];

  always #10 clk_i = ~clk_i;

  fir_conv_seq #(.RAM_AW(RAM_AW), .ROM_AW(ROM_AW), .TAP_W(TAP_W), .RATIO_W(RATIO_W),
                 .DATA_W(DATA_W), .COEF_W(COEF_W)) u_dut (.*);

  // synchronous memories, one cycle read latency
  always @(posedge clk_i) begin
    smp_i  <= smem[{smp_ch_o, smp_addr_o}];
    coef_i <= cmem[coef_addr_o];
  end

  // tap monitor: expected address walk
  always @(negedge clk_i) begin
    if (rst_ni && rd_o) begin
      if (int'(smp_addr_o) != m_s || int'(coef_addr_o) != m_c || int'(smp_ch_o) != m_ch)
        addr_err++;
      tcnt[m_ch & 1]++;
      if (m_c + m_step >= CSPAN) begin
        m_ch = 1; m_s = m_sb; m_c = m_cb;
      end else begin
        m_s = (m_s + SSPAN - 1) % SSPAN; m_c = m_c + m_step;
      end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  task automatic chk(string req, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_step(int r);
    int s;
    if (r >= ONE) return UNIT;
    s = (UNIT * r) / ONE;
    return (s < 1) ? 1 : s;
  endfunction

  function automatic longint ref_out(int ch, int sb, int cb, int st);
    longint acc = 0, sh;
    int s = sb, c = cb;
    while (1) begin
      acc += longint'(smem[ch * SSPAN + s]) * longint'(cmem[c]);
      if (c + st >= CSPAN) break;
      s = (s + SSPAN - 1) % SSPAN; c += st;
    end
    sh = acc >>> (COEF_W - 1);
    if (sh > 2 ** (DATA_W - 1) - 1) sh = 2 ** (DATA_W - 1) - 1;
    if (sh < -(2 ** (DATA_W - 1))) sh = -(2 ** (DATA_W - 1));
    return sh;
  endfunction

  task automatic launch(int r, int sb, int cb);
    m_step = exp_step(r); m_sb = sb; m_cb = cb;
    m_s = sb; m_c = cb; m_ch = 0; addr_err = 0; tcnt[0] = 0; tcnt[1] = 0;
    @(negedge clk_i);
    ratio_i = (RATIO_W+1)'(r); smp_base_i = RAM_AW'(sb); coef_base_i = ROM_AW'(cb);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic finish_run(int r, int sb, int cb, int taps, bit busy_poke);
    longint rl, rr;
    int n;
    rl = ref_out(0, sb, cb, exp_step(r));
    rr = ref_out(1, sb, cb, exp_step(r));
    n = 0;
    while (!left_vld_o && n < 3000) begin @(negedge clk_i); n++; end
    chk("R7 left result", longint'($signed(left_o)), rl);
    chk("R8 right not with left", longint'(right_vld_o), 0);
    n = 0;
    while (!right_vld_o && n < 3000) begin @(negedge clk_i); n++; end
    chk("R7 right result", longint'($signed(right_o)), rr);
    chk("R5 left tap count", tcnt[0], taps);
    chk("R6 right tap count", tcnt[1], taps);
    chk(busy_poke ? "R9 address walk" : "R2 R3 R4 address walk", addr_err, 0);
  endtask

  initial begin
    for (int i = 0; i < 2 * SSPAN; i++) smem[i] = DATA_W'((i * 29 + 7) % 256 - 128);
    for (int i = 0; i < CSPAN; i++)     cmem[i] = COEF_W'((i * 53 + 11) % 256 - 128);
    m_s = 0; m_c = 0; m_ch = 0; m_step = 1; m_sb = 0; m_cb = 0; addr_err = 0;
    tcnt[0] = 0; tcnt[1] = 0;
    repeat (3) @(negedge clk_i);
    chk("R1 rd after reset", rd_o, 0);
    chk("R1 valids after reset", {left_vld_o, right_vld_o}, 0);
    chk("R1 results after reset", {left_o, right_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int v = 0; v < NV; v++) begin
      launch(VR[v], VS[v], VC[v]);
      finish_run(VR[v], VS[v], VC[v], VT[v], 1'b0);
      repeat (2) @(negedge clk_i);
    end

    // R9: new start and inputs while busy are ignored
    launch(16, 10, 0);
    repeat (3) @(negedge clk_i);
    start_i = 1'b1; ratio_i = 5'd8; smp_base_i = 5'd7; coef_base_i = 6'd1;
    @(negedge clk_i);
    start_i = 1'b0;
    finish_run(16, 10, 0, 8, 1'b1);
    repeat (5) @(negedge clk_i);
    chk("R9 no second run", rd_o, 0);
    chk("R8 left held", longint'($signed(left_o)), ref_out(0, 10, 0, UNIT));
    chk("R8 valids low", {left_vld_o, right_vld_o}, 0);

    // R7 saturation both ways
    for (int i = 0; i < CSPAN; i++) cmem[i] = 8'sd127;
    for (int i = 0; i < 2 * SSPAN; i++) smem[i] = (i < SSPAN) ? 8'sd127 : -8'sd128;
    launch(1, 0, 0);
    finish_run(1, 0, 0, 64, 1'b0);
    chk("R7 positive clip", longint'($signed(left_o)), 127);
    chk("R7 negative clip", longint'($signed(right_o)), -128);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule